// File: doc/BRIEF.md
# Receive Ring Fetcher

This block walks a circular table of receive-buffer descriptors kept in system memory. Each table entry is four 16-bit fields; when a fetch is triggered the block reads the entry at its read pointer through a simple request/response memory port. It loads the current receive buffer address and that buffer's remaining word count from the entry, then steps the read pointer to the next entry, wrapping to the table start when it reaches the table end.

A fetch is started by a command strobe, by a write-one-to-clear of the exhausted flag, or by the block itself when a stored packet leaves less space in the current buffer than the end-of-buffer threshold. When the advanced read pointer lands on the software write pointer, the table is exhausted: a sticky flag is set and, if masked in, the interrupt line rises. Table pointers are 16 bits wide and are joined with a shared upper-address half to form the 32-bit memory address.

The fetch engine is a four-state machine. `ST_IDLE` waits for a trigger (transition *launch*). `ST_ISSUE` holds a read request until the memory accepts it (transition *accepted*). `ST_AWAIT` waits for the response word and stores it (transition *more fields*, back to `ST_ISSUE`, or *last field*, on to `ST_FINISH`). `ST_FINISH` updates the read pointer and the exhausted flag, then returns to `ST_IDLE` (transition *retire*).

Top module: `rx_ring_fetcher`

## Requirements
- R1: After reset, busy, the exhausted flag, the interrupt, the last-in-buffer flag and the memory request are low; the read pointer, buffer address and buffer word count are zero, and the end-of-buffer threshold is 0x02F8.
- R2: A fetch issues exactly four reads, in this order: buffer address low half, buffer address high half, word count low half, word count high half. Read k goes to {upper_addr, rd_ptr} + 2k in narrow mode (wide_mode=0) and + 4k in wide mode (wide_mode=1). The results appear as buf_addr = {field1, field0} and buf_words = {field3, field2}.
- R3: When a fetch completes, rd_ptr advances by 8 in narrow mode and by 16 in wide mode. Otherwise it changes only on a software pointer write.
- R4: If the advanced rd_ptr equals ring_end, rd_ptr is loaded with ring_start instead.
- R5: If the final rd_ptr after a fetch equals ring_wr, the exhausted flag rbe is set and stays set until it is cleared. irq is high exactly when rbe and irq_mask are both high.
- R6: busy is high from the cycle after a trigger until the fetch retires. Any trigger that arrives while busy is ignored.
- R7: A pulse on rbe_clr clears rbe at the next edge and, when idle, starts a fetch.
- R8: A pulse on pkt_done lowers buf_words by pkt_bytes/2 (integer division). If the result is strictly below the threshold, last_in_buf pulses in the next cycle and a fetch starts one cycle later. A result equal to the threshold does neither.
- R9: A write to the threshold stores the written value with bit 0 forced to zero.
- R10: A memory request, once raised, keeps its address and stays valid until mem_req_ready is high.
- R11: A fetch command and an rbe_clr pulse in the same cycle clear rbe and start one single fetch (four reads, one pointer step).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wide_mode | input | 1 | 1: each field takes a 32-bit slot; 0: 16-bit slots |
| upper_addr | input | 16 | Upper address half shared by all table pointers |
| ring_start | input | 16 | Table start pointer |
| ring_end | input | 16 | Table end pointer (one past the last entry) |
| ring_wr | input | 16 | Software write pointer |
| rd_ptr_we | input | 1 | Software write strobe for the read pointer |
| rd_ptr_wdata | input | 16 | Value for the read pointer |
| fetch_cmd | input | 1 | Fetch command strobe |
| rbe_clr | input | 1 | Write-one-to-clear strobe for the exhausted flag |
| irq_mask | input | 1 | Interrupt enable for the exhausted flag |
| eob_we | input | 1 | Threshold write strobe |
| eob_wdata | input | 16 | Threshold write value |
| pkt_done | input | 1 | A packet has been stored in the current buffer |
| pkt_bytes | input | 16 | Byte length of that packet |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_addr | output | 32 | Byte address of the read |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 16 | Read data |
| busy | output | 1 | Fetch in progress (self-clearing command bit) |
| rd_ptr | output | 16 | Read pointer |
| rbe | output | 1 | Table-exhausted flag |
| irq | output | 1 | Interrupt request |
| buf_addr | output | 32 | Current buffer address |
| buf_words | output | 32 | Words remaining in current buffer |
| eob | output | 16 | End-of-buffer threshold |
| last_in_buf | output | 1 | Packet just stored left too little space |

## Verification
The exhausted-flag clear and a fetch command can land in the same cycle. Both ask the engine to launch, and the clear also changes flag state. The bench first drives the table into exhaustion, then raises fetch_cmd and rbe_clr together on one edge. It judges the result by the flag being low at the next sample, by exactly four memory reads being counted, and by a single pointer step.

// File: rtl/rrf_pkg.sv
package rrf_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_AWAIT,
        ST_FINISH
    } fetch_state_t;

    localparam int unsigned ENTRY_FIELDS = 4;
    localparam int unsigned FLD_ADDR_LO  = 0;
    localparam int unsigned FLD_ADDR_HI  = 1;
    localparam int unsigned FLD_CNT_LO   = 2;
    localparam int unsigned FLD_CNT_HI   = 3;
endpackage

// File: rtl/rrf_fetch_fsm.sv
module rrf_fetch_fsm
    import rrf_pkg::*;
#(
    parameter int unsigned FW = 16,
    parameter int unsigned AW = 32,
    parameter int unsigned NF = ENTRY_FIELDS,
    localparam int unsigned IW = $clog2(NF),
    localparam int unsigned SH_N = $clog2(FW / 8),
    localparam int unsigned SH_W = SH_N + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          wide,
    input  logic [AW-1:0] base_addr,
    output logic          mem_req_valid,
    output logic [AW-1:0] mem_req_addr,
    input  logic          mem_req_ready,
    input  logic          mem_rsp_valid,
    input  logic [FW-1:0] mem_rsp_data,
    output logic          busy,
    output logic          field_we,
    output logic [IW-1:0] field_idx,
    output logic [FW-1:0] field_data,
    output logic          done
);
    fetch_state_t state, nxt;
    logic [IW-1:0] idx;
    logic          last_field;

    assign last_field = (idx == IW'(NF - 1));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // field counter
    always_ff @(posedge clk) begin
        if (!rst_n)                                  idx <= '0;
        else if (state == ST_IDLE)                   idx <= '0;
        else if (state == ST_AWAIT && mem_rsp_valid) idx <= idx + 1'b1;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (start)         nxt = ST_ISSUE;
            ST_ISSUE:  if (mem_req_ready) nxt = ST_AWAIT;
            ST_AWAIT:  if (mem_rsp_valid) nxt = last_field ? ST_FINISH : ST_ISSUE;
            ST_FINISH:                    nxt = ST_IDLE;
            default:                      nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        mem_req_valid = 1'b0;
        field_we      = 1'b0;
        done          = 1'b0;
        busy          = 1'b1;
        unique case (state)
            ST_IDLE:   busy          = 1'b0;
            ST_ISSUE:  mem_req_valid = 1'b1;
            ST_AWAIT:  field_we      = mem_rsp_valid;
            ST_FINISH: done          = 1'b1;
            default:   busy          = 1'b0;
        endcase
    end

    assign mem_req_addr = wide ? base_addr + (AW'(idx) << SH_W)
                               : base_addr + (AW'(idx) << SH_N);
    assign field_idx  = idx;
    assign field_data = mem_rsp_data;

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R6
    busy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
endmodule

// File: rtl/rrf_space.sv
module rrf_space
    import rrf_pkg::*;
#(
    parameter int unsigned FW = 16,
    parameter int unsigned NF = ENTRY_FIELDS,
    parameter logic [FW-1:0] EOB_RST = 16'h02F8,
    localparam int unsigned IW = $clog2(NF)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            field_we,
    input  logic [IW-1:0]   field_idx,
    input  logic [FW-1:0]   field_data,
    input  logic            pkt_done,
    input  logic [FW-1:0]   pkt_bytes,
    input  logic            eob_we,
    input  logic [FW-1:0]   eob_wdata,
    output logic [2*FW-1:0] buf_addr,
    output logic [2*FW-1:0] buf_words,
    output logic [FW-1:0]   eob,
    output logic            last_in_buf
);
    logic [2*FW-1:0] remain_nxt;
    logic            low_space;

    assign remain_nxt = buf_words - (2*FW)'(pkt_bytes >> 1);
    assign low_space  = remain_nxt < (2*FW)'(eob);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_addr    <= '0;
            buf_words   <= '0;
            last_in_buf <= 1'b0;
        end else begin
            last_in_buf <= pkt_done && !field_we && low_space;
            if (field_we) begin
                case (field_idx)
                    IW'(FLD_ADDR_LO): buf_addr[FW-1:0]     <= field_data;
                    IW'(FLD_ADDR_HI): buf_addr[2*FW-1:FW]  <= field_data;
                    IW'(FLD_CNT_LO):  buf_words[FW-1:0]    <= field_data;
                    IW'(FLD_CNT_HI):  buf_words[2*FW-1:FW] <= field_data;
                    default: ;
                endcase
            end else if (pkt_done) begin
                buf_words <= remain_nxt;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      eob <= EOB_RST;
        else if (eob_we) eob <= eob_wdata & ~FW'(1);
    end

    // R8
    low_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last_in_buf |-> (buf_words < (2*FW)'($past(eob))));
endmodule

// File: rtl/rx_ring_fetcher.sv
module rx_ring_fetcher
    import rrf_pkg::*;
#(
    parameter int unsigned FW = 16,
    parameter logic [FW-1:0] EOB_RST = 16'h02F8,
    localparam int unsigned NF = ENTRY_FIELDS,
    localparam int unsigned IW = $clog2(NF),
    localparam int unsigned AW = 2 * FW,
    localparam logic [FW-1:0] STEP_N = FW'(NF * FW / 8),
    localparam logic [FW-1:0] STEP_W = FW'(2 * NF * FW / 8)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wide_mode,
    input  logic [FW-1:0] upper_addr,
    input  logic [FW-1:0] ring_start,
    input  logic [FW-1:0] ring_end,
    input  logic [FW-1:0] ring_wr,
    input  logic          rd_ptr_we,
    input  logic [FW-1:0] rd_ptr_wdata,
    input  logic          fetch_cmd,
    input  logic          rbe_clr,
    input  logic          irq_mask,
    input  logic          eob_we,
    input  logic [FW-1:0] eob_wdata,
    input  logic          pkt_done,
    input  logic [FW-1:0] pkt_bytes,
    output logic          mem_req_valid,
    output logic [AW-1:0] mem_req_addr,
    input  logic          mem_req_ready,
    input  logic          mem_rsp_valid,
    input  logic [FW-1:0] mem_rsp_data,
    output logic          busy,
    output logic [FW-1:0] rd_ptr,
    output logic          rbe,
    output logic          irq,
    output logic [AW-1:0] buf_addr,
    output logic [AW-1:0] buf_words,
    output logic [FW-1:0] eob,
    output logic          last_in_buf
);
    logic          start, done, field_we;
    logic [IW-1:0] field_idx;
    logic [FW-1:0] field_data;
    logic [FW-1:0] ptr_adv, ptr_nxt;

    assign start   = !busy && (fetch_cmd || rbe_clr || last_in_buf);
    assign ptr_adv = rd_ptr + (wide_mode ? STEP_W : STEP_N);
    assign ptr_nxt = (ptr_adv == ring_end) ? ring_start : ptr_adv;

    rrf_fetch_fsm #(.FW(FW), .AW(AW), .NF(NF)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .wide(wide_mode),
        .base_addr({upper_addr, rd_ptr}),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .busy(busy), .field_we(field_we),
        .field_idx(field_idx), .field_data(field_data), .done(done)
    );

    rrf_space #(.FW(FW), .NF(NF), .EOB_RST(EOB_RST)) u_space (
        .clk(clk), .rst_n(rst_n), .field_we(field_we), .field_idx(field_idx),
        .field_data(field_data), .pkt_done(pkt_done), .pkt_bytes(pkt_bytes),
        .eob_we(eob_we), .eob_wdata(eob_wdata), .buf_addr(buf_addr),
        .buf_words(buf_words), .eob(eob), .last_in_buf(last_in_buf)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)         rd_ptr <= '0;
        else if (done)      rd_ptr <= ptr_nxt;
        else if (rd_ptr_we) rd_ptr <= rd_ptr_wdata;
    end

    // set on retire wins over a same-cycle clear
    always_ff @(posedge clk) begin
        if (!rst_n)                          rbe <= 1'b0;
        else if (done && ptr_nxt == ring_wr) rbe <= 1'b1;
        else if (rbe_clr)                    rbe <= 1'b0;
    end

    assign irq = rbe && irq_mask;

    // R5
    rbe_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rbe) |-> $past(done));

    // R3
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!done && !rd_ptr_we) |=> $stable(rd_ptr));
endmodule

// File: tb/tb_rx_ring_fetcher.sv
`timescale 1ns/1ps
module tb_rx_ring_fetcher;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wide_mode = 1'b0;
    logic [15:0] upper_addr = 16'h0012;
    logic [15:0] ring_start = '0, ring_end = '0, ring_wr = '0;
    logic        rd_ptr_we = 1'b0;
    logic [15:0] rd_ptr_wdata = '0;
    logic        fetch_cmd = 1'b0, rbe_clr = 1'b0, irq_mask = 1'b1;
    logic        eob_we = 1'b0;
    logic [15:0] eob_wdata = '0;
    logic        pkt_done = 1'b0;
    logic [15:0] pkt_bytes = '0;
    logic        mem_req_valid, mem_req_ready, mem_rsp_valid;
    logic [31:0] mem_req_addr;
    logic [15:0] mem_rsp_data;
    logic        busy, rbe, irq, last_in_buf;
    logic [15:0] rd_ptr, eob;
    logic [31:0] buf_addr, buf_words;

    int n_chk = 0, n_err = 0;
    logic        stall = 1'b0;
    logic [7:0]  cyc = '0;
    int          req_n = 0;
    logic [15:0] fld [4];
    logic [31:0] rec [4];

    always #4 clk = ~clk;

    assign mem_req_ready = !stall || cyc[0];

    rx_ring_fetcher dut (.*);

    // memory model: answers one cycle after acceptance
    always @(posedge clk) begin
        cyc <= cyc + 8'd1;
        if (!rst_n) begin
            mem_rsp_valid <= 1'b0;
            mem_rsp_data  <= '0;
        end else if (mem_req_valid && mem_req_ready) begin
            mem_rsp_valid <= 1'b1;
            mem_rsp_data  <= fld[req_n % 4];
            rec[req_n % 4] <= mem_req_addr;
            req_n <= req_n + 1;
        end else begin
            mem_rsp_valid <= 1'b0;
        end
    end

    typedef struct packed {
        logic        wide;
        logic [15:0] start;
        logic [15:0] fin;
        logic [15:0] wr;
        logic [15:0] ptr0;
        logic [15:0] ptr_exp;
        logic        rbe_exp;
    } vec_t;

    localparam int NV = 5;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 16'h0100, 16'h0140, 16'h0000, 16'h0100, 16'h0108, 1'b0},
        '{1'b0, 16'h0100, 16'h0140, 16'h0000, 16'h0138, 16'h0100, 1'b0},
        '{1'b1, 16'h0200, 16'h0240, 16'h0000, 16'h0200, 16'h0210, 1'b0},
        '{1'b1, 16'h0200, 16'h0240, 16'h0200, 16'h0230, 16'h0200, 1'b1},
        '{1'b0, 16'h0100, 16'h0140, 16'h0108, 16'h0100, 16'h0108, 1'b1}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 300; k++) begin
            if (!busy) return;
            @(negedge clk);
        end
        chk("R6 fetch did not retire", 32'd1, 32'd0);
    endtask

    task automatic set_ptr(input logic [15:0] p);
        @(negedge clk); rd_ptr_we = 1'b1; rd_ptr_wdata = p;
        @(negedge clk); rd_ptr_we = 1'b0;
    endtask

    task automatic do_fetch();
        @(negedge clk); fetch_cmd = 1'b1;
        @(negedge clk); fetch_cmd = 1'b0;
        wait_idle();
    endtask

    task automatic send_pkt(input logic [15:0] b);
        @(negedge clk); pkt_done = 1'b1; pkt_bytes = b;
        @(negedge clk); pkt_done = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int base;
        fld[0] = '0; fld[1] = '0; fld[2] = '0; fld[3] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", busy, 0);
        chk("R1 rbe", rbe, 0);
        chk("R1 irq", irq, 0);
        chk("R1 eob", eob, 32'h02F8);
        chk("R1 rd_ptr", rd_ptr, 0);
        chk("R1 buf_words", buf_words, 0);
        chk("R1 buf_addr", buf_addr, 0);
        chk("R1 req", mem_req_valid, 0);
        chk("R1 last", last_in_buf, 0);

        // table walk: R2 R3 R4 R5 R10
        for (int i = 0; i < NV; i++) begin
            logic [31:0] b;
            logic [2:0]  sh;
            stall = i[0];
            fld[0] = 16'hA000 + 16'(i); fld[1] = 16'h00C0;
            fld[2] = 16'h0400 + 16'(i); fld[3] = 16'h0001;
            wide_mode = VECS[i].wide; ring_start = VECS[i].start;
            ring_end = VECS[i].fin; ring_wr = VECS[i].wr;
            set_ptr(VECS[i].ptr0);
            base = req_n;
            do_fetch();
            b  = {upper_addr, VECS[i].ptr0};
            sh = VECS[i].wide ? 3'd4 : 3'd2;
            chk("R2 read count", req_n - base, 4);
            for (int k = 0; k < 4; k++)
                chk("R2 R10 read address", rec[k], b + 32'(k) * 32'(sh));
            chk("R2 buf_addr", buf_addr, {16'h00C0, 16'hA000 + 16'(i)});
            chk("R2 buf_words", buf_words, {16'h0001, 16'h0400 + 16'(i)});
            chk("R3 R4 rd_ptr", rd_ptr, VECS[i].ptr_exp);
            chk("R5 rbe", rbe, VECS[i].rbe_exp);
            chk("R5 irq", irq, VECS[i].rbe_exp);
        end
        stall = 1'b0;

        // R5 mask gates the interrupt
        @(negedge clk); irq_mask = 1'b0;
        @(negedge clk);
        chk("R5 irq masked", irq, 0);
        irq_mask = 1'b1;

        // R9 threshold bit 0 forced low
        @(negedge clk); eob_we = 1'b1; eob_wdata = 16'h0101;
        @(negedge clk); eob_we = 1'b0;
        chk("R9 eob", eob, 32'h0100);
        @(negedge clk); eob_we = 1'b1; eob_wdata = 16'h02F8;
        @(negedge clk); eob_we = 1'b0;

        // R7 clear starts a fetch
        wide_mode = 1'b0; ring_start = 16'h0100; ring_end = 16'h0140; ring_wr = 16'h0000;
        set_ptr(16'h0110);
        base = req_n;
        @(negedge clk); rbe_clr = 1'b1;
        @(negedge clk); rbe_clr = 1'b0;
        chk("R7 rbe cleared", rbe, 0);
        chk("R7 busy", busy, 1);
        wait_idle();
        chk("R7 reads", req_n - base, 4);
        chk("R7 rd_ptr", rd_ptr, 32'h0118);

        // R6 command while busy is ignored
        set_ptr(16'h0120);
        base = req_n;
        @(negedge clk); fetch_cmd = 1'b1;
        @(negedge clk); fetch_cmd = 1'b0;
        @(negedge clk); fetch_cmd = 1'b1;
        @(negedge clk); fetch_cmd = 1'b0;
        wait_idle();
        repeat (4) @(negedge clk);
        chk("R6 reads", req_n - base, 4);
        chk("R6 rd_ptr", rd_ptr, 32'h0128);
        chk("R6 idle", busy, 0);

        // R11 command and clear together
        ring_wr = 16'h0108;
        set_ptr(16'h0100);
        do_fetch();
        chk("R11 setup rbe", rbe, 1);
        ring_wr = 16'h0000;
        base = req_n;
        @(negedge clk); fetch_cmd = 1'b1; rbe_clr = 1'b1;
        @(negedge clk); fetch_cmd = 1'b0; rbe_clr = 1'b0;
        chk("R11 rbe", rbe, 0);
        wait_idle();
        repeat (3) @(negedge clk);
        chk("R11 reads", req_n - base, 4);
        chk("R11 rd_ptr", rd_ptr, 32'h0110);

        // R8 space tracking
        fld[0] = 16'hB000; fld[1] = 16'h0001; fld[2] = 16'h0400; fld[3] = 16'h0000;
        do_fetch();
        chk("R8 setup words", buf_words, 32'h0400);
        base = req_n;
        send_pkt(16'h0200);
        chk("R8 words 300", buf_words, 32'h0300);
        chk("R8 no flag", last_in_buf, 0);
        send_pkt(16'h0010);
        chk("R8 words at threshold", buf_words, 32'h02F8);
        chk("R8 equal no flag", last_in_buf, 0);
        repeat (3) @(negedge clk);
        chk("R8 no fetch", req_n - base, 0);
        fld[2] = 16'h0800;
        send_pkt(16'h0003);
        chk("R8 words below", buf_words, 32'h02F7);
        chk("R8 flag", last_in_buf, 1);
        @(negedge clk);
        chk("R8 fetch started", busy, 1);
        wait_idle();
        chk("R8 reads", req_n - base, 4);
        chk("R8 reloaded words", buf_words, 32'h0800);
        chk("R8 rd_ptr", rd_ptr, 32'h0120);

        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule